// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block keeps a 17-bit software interrupt word and a 4-bit processor interrupt level. Each bit of the word drives one pending-interrupt output, and whether that output is raised depends on the current interrupt level. Software can update the word in three ways: it can load the word whole, it can set chosen bits without touching the others, or it can clear chosen bits without touching the others. Two hardware event inputs can also set the two timer-match bits directly.

The lowest bit (timer match) and the highest bit (system timer match) use a fixed gate: they are pending only while the level is below 14. The fifteen middle bits use their own index: each one is pending only while its index is strictly greater than the level. The pending outputs are derived from the stored word and level, so a change to either is reflected on the outputs at the same clock edge that stores it. Choosing between several pending levels and steering the trap are left to the consumer of the pending vector.

Top module: `swint_ctrl`

## Requirements
- R1: While `rst_n` is low the word reads 0, the level reads 0 and `pend_o` is all zero.
- R2: A write with `wr_addr` = 0 loads `wr_data[16:0]` into the word; reading `rd_addr` 0, 1 or 2 returns the word in `rd_data[16:0]` with `rd_data[31:17]` zero.
- R3: A write with `wr_addr` = 1 makes the new word the old word ORed with `wr_data`.
- R4: A write with `wr_addr` = 2 makes the new word the old word ANDed with the inverse of `wr_data`.
- R5: A write with `wr_addr` = 3 loads `wr_data[3:0]` into the level; reading `rd_addr` 3 returns the level in `rd_data[3:0]` with all higher bits zero; other read addresses (4 to 7) return zero.
- R6: For each bit i from 1 to 15, `pend_o[i]` is 1 exactly when word bit i is 1 and i is greater than the level.
- R7: `pend_o[0]` and `pend_o[16]` are 1 exactly when the matching word bit is 1 and the level is below 14.
- R8: A high `evt_systick` in a cycle sets word bit 16 at that clock edge, also when a clear or a direct write of that bit happens in the same cycle.
- R9: A high `evt_tick` in a cycle sets word bit 0 at that clock edge, also when a clear or a direct write of that bit happens in the same cycle.
- R10: Word, level and `pend_o` change only at the clock edge that ends a cycle with a write or an event; a write to addresses 4 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write target: 0 load, 1 set bits, 2 clear bits, 3 level |
| wr_data | input | 17 | Write data |
| rd_addr | input | 3 | Read target: 0..2 word, 3 level, others zero |
| rd_data | output | 32 | Read data, zero-extended |
| evt_tick | input | 1 | Hardware event that sets word bit 0 |
| evt_systick | input | 1 | Hardware event that sets word bit 16 |
| pend_o | output | 17 | Pending interrupt per word bit |

## Verification
The gating is tried with the level at 0, at mid values such as 5, 7 and 13, and at 14 and 15, so that index-greater-than-level for the middle bits is told apart from greater-or-equal (bit 7 against level 7) and the fixed threshold of the end bits is told apart from index comparison (bits 0 and 16 at level 13 and 14). The word is changed through the load, set and clear paths with overlapping masks, which separates OR from load and AND-NOT from AND. Events arrive together with clears of the same bits to show event priority, and writes to unused addresses and idle cycles show that nothing else moves the state.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int SW_BITS  = 17;
  localparam int LVL_W    = 4;
  localparam int RD_W     = 32;
  localparam int ADR_W    = 3;
  localparam int END_GATE = 14;

  typedef enum logic [ADR_W-1:0] {
    ADR_LOAD  = 3'd0,
    ADR_SET   = 3'd1,
    ADR_CLEAR = 3'd2,
    ADR_LEVEL = 3'd3
  } swint_adr_e;
endpackage

// File: rtl/swint_wr_merge.sv
module swint_wr_merge
  import swint_pkg::*;
#(
  parameter int NBITS = SW_BITS,
  parameter int LW    = LVL_W
) (
  input  logic               wr_en,
  input  logic [ADR_W-1:0]   wr_addr,
  input  logic [NBITS-1:0]   wr_data,
  input  logic               evt_tick,
  input  logic               evt_systick,
  input  logic [NBITS-1:0]   word_q,
  input  logic [LW-1:0]      lvl_q,
  output logic [NBITS-1:0]   word_d,
  output logic               word_en,
  output logic [LW-1:0]      lvl_d,
  output logic               lvl_en
);
  logic [NBITS-1:0] sw_next;
  logic             sw_hit;

  always_comb begin
    sw_next = word_q;
    sw_hit  = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        ADR_LOAD:  begin sw_next = wr_data;            sw_hit = 1'b1; end
        ADR_SET:   begin sw_next = word_q | wr_data;   sw_hit = 1'b1; end
        ADR_CLEAR: begin sw_next = word_q & ~wr_data;  sw_hit = 1'b1; end
        default:   begin sw_next = word_q;             sw_hit = 1'b0; end
      endcase
    end
  end

  always_comb begin
    word_d           = sw_next;
    word_d[0]        = sw_next[0] | evt_tick;
    word_d[NBITS-1]  = sw_next[NBITS-1] | evt_systick;
    word_en          = sw_hit | evt_tick | evt_systick;
  end

  always_comb begin
    lvl_en = wr_en && (wr_addr == ADR_LEVEL);
    lvl_d  = lvl_en ? wr_data[LW-1:0] : lvl_q;
  end
endmodule

// File: rtl/swint_gate.sv
module swint_gate
  import swint_pkg::*;
#(
  parameter int NBITS  = SW_BITS,
  parameter int LW     = LVL_W,
  parameter int THRESH = END_GATE
) (
  input  logic [NBITS-1:0] word_q,
  input  logic [LW-1:0]    lvl_q,
  output logic [NBITS-1:0] pend
);
  localparam logic [LW-1:0] TH = LW'(THRESH);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (i == 0 || i == NBITS - 1) begin : g_end
      assign pend[i] = word_q[i] && (lvl_q < TH);
    end else begin : g_mid
      localparam logic [LW-1:0] IDX = LW'(i);
      assign pend[i] = word_q[i] && (IDX > lvl_q);
    end
  end
endmodule

// File: rtl/swint_rd_mux.sv
module swint_rd_mux
  import swint_pkg::*;
#(
  parameter int NBITS = SW_BITS,
  parameter int LW    = LVL_W,
  parameter int DW    = RD_W
) (
  input  logic [ADR_W-1:0] rd_addr,
  input  logic [NBITS-1:0] word_q,
  input  logic [LW-1:0]    lvl_q,
  output logic [DW-1:0]    rd_data
);
  always_comb begin
    unique case (rd_addr)
      ADR_LOAD, ADR_SET, ADR_CLEAR: rd_data = DW'(word_q);
      ADR_LEVEL:                    rd_data = DW'(lvl_q);
      default:                      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int NBITS  = SW_BITS,
  parameter int LW     = LVL_W,
  parameter int DW     = RD_W,
  parameter int THRESH = END_GATE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [NBITS-1:0] wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             evt_tick,
  input  logic             evt_systick,
  output logic [NBITS-1:0] pend_o
);
  logic [NBITS-1:0] word_q, word_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic             word_en, lvl_en;

  swint_wr_merge #(.NBITS(NBITS), .LW(LW)) u_merge (
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .evt_tick    (evt_tick),
    .evt_systick (evt_systick),
    .word_q      (word_q),
    .lvl_q       (lvl_q),
    .word_d      (word_d),
    .word_en     (word_en),
    .lvl_d       (lvl_d),
    .lvl_en      (lvl_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  swint_gate #(.NBITS(NBITS), .LW(LW), .THRESH(THRESH)) u_gate (
    .word_q (word_q),
    .lvl_q  (lvl_q),
    .pend   (pend_o)
  );

  swint_rd_mux #(.NBITS(NBITS), .LW(LW), .DW(DW)) u_rd (
    .rd_addr (rd_addr),
    .word_q  (word_q),
    .lvl_q   (lvl_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/swint_ctrl_chk.sv
module swint_ctrl_chk
  import swint_pkg::*;
#(
  parameter int NBITS  = SW_BITS,
  parameter int LW     = LVL_W,
  parameter int THRESH = END_GATE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [ADR_W-1:0] wr_addr,
  input logic [NBITS-1:0] wr_data,
  input logic             evt_tick,
  input logic             evt_systick,
  input logic [NBITS-1:0] word_q,
  input logic [LW-1:0]    lvl_q,
  input logic [NBITS-1:0] pend_o
);
  localparam logic [LW-1:0] TH = LW'(THRESH);

  AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_SET) |=> ((word_q & $past(wr_data)) == $past(wr_data))); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CLEAR && !evt_tick && !evt_systick)
      |=> ((word_q & $past(wr_data)) == '0)); // R4

  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_LEVEL) |=> (lvl_q == $past(wr_data[LW-1:0]))); // R5

  AST_PEND_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~word_q) == '0)); // R6

  AST_END_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q >= TH) |-> (!pend_o[0] && !pend_o[NBITS-1])); // R7

  AST_SYSTICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_systick |=> word_q[NBITS-1]); // R8

  AST_TICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tick |=> word_q[0]); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !evt_tick && !evt_systick)
      |=> ($stable(word_q) && $stable(lvl_q) && $stable(pend_o))); // R10
endmodule

bind swint_ctrl swint_ctrl_chk #(.NBITS(NBITS), .LW(LW), .THRESH(THRESH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .evt_tick    (evt_tick),
  .evt_systick (evt_systick),
  .word_q      (word_q),
  .lvl_q       (lvl_q),
  .pend_o      (pend_o)
);

// File: tb/swint_ctrl_tb_top.sv
module swint_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 17;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [NB-1:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        evt_tick = 1'b0;
  logic        evt_systick = 1'b0;
  logic [NB-1:0] pend_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [NB-1:0] m_word = '0;
  logic [3:0]    m_lvl  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_tick(evt_tick), .evt_systick(evt_systick), .pend_o(pend_o)
  );

  // {evt_systick, evt_tick, wr_en, addr[2:0], data[16:0]}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 3'd0, 17'h1FFFF},
    {1'b0, 1'b0, 1'b1, 3'd3, 17'h00005},
    {1'b0, 1'b0, 1'b1, 3'd2, 17'h0FFF0},
    {1'b0, 1'b0, 1'b1, 3'd3, 17'h0000E},
    {1'b0, 1'b0, 1'b1, 3'd3, 17'h0000D},
    {1'b0, 1'b0, 1'b1, 3'd1, 17'h0C000},
    {1'b0, 1'b0, 1'b1, 3'd3, 17'h0000F},
    {1'b0, 1'b0, 1'b1, 3'd0, 17'h00000},
    {1'b0, 1'b0, 1'b1, 3'd3, 17'h00000},
    {1'b1, 1'b0, 1'b1, 3'd2, 17'h10000},
    {1'b0, 1'b1, 1'b1, 3'd2, 17'h00001},
    {1'b0, 1'b0, 1'b1, 3'd5, 17'h1FFFF},
    {1'b0, 1'b0, 1'b1, 3'd3, 17'h1FFF7},
    {1'b0, 1'b0, 1'b1, 3'd1, 17'h00180},
    {1'b0, 1'b0, 1'b0, 3'd0, 17'h1FFFF},
    {1'b1, 1'b1, 1'b1, 3'd2, 17'h1FFFF}
  };

  function automatic logic [NB-1:0] exp_pend(input logic [NB-1:0] w, input logic [3:0] l);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) begin
      if (i == 0 || i == NB - 1) p[i] = w[i] && (l < 4'd14);
      else                       p[i] = w[i] && (i > int'(l));
    end
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [22:0] v);
    if (v[22]) return "R8";
    if (v[21]) return "R9";
    if (!v[20]) return "R10";
    case (v[19:17])
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check_all(input string tag);
    rd_addr = 3'd0; #1;
    check({tag, " word"}, rd_data, 32'(m_word));
    rd_addr = 3'd2; #1;
    check({tag, " word via clear addr"}, rd_data, 32'(m_word));
    rd_addr = 3'd3; #1;
    check({tag, " level"}, rd_data, 32'(m_lvl));
    check("R6 R7 pend", 32'(pend_o), 32'(exp_pend(m_word, m_lvl)));
  endtask

  task automatic apply(input logic [22:0] v);
    logic [NB-1:0] d;
    @(negedge clk);
    evt_systick = v[22]; evt_tick = v[21]; wr_en = v[20];
    wr_addr = v[19:17]; wr_data = v[16:0];
    d = v[16:0];
    if (v[20]) begin
      case (v[19:17])
        3'd0: m_word = d;
        3'd1: m_word = m_word | d;
        3'd2: m_word = m_word & ~d;
        3'd3: m_lvl  = d[3:0];
        default: ;
      endcase
    end
    if (v[22]) m_word[NB-1] = 1'b1;
    if (v[21]) m_word[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; evt_tick = 1'b0; evt_systick = 1'b0;
    check_all(tag_of(v));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 2);
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) apply(VEC[k]);

    // R5 unused read addresses return zero
    rd_addr = 3'd6; #1;
    check("R5 unused read", rd_data, 32'd0);

    // R10 pending only moves on the edge: held write before the edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 17'h00000;
    #1;
    check("R10 before edge", 32'(pend_o), 32'(exp_pend(m_word, m_lvl)));
    m_word = '0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    check_all("R10");

    // R9 event with direct write clearing bit 0
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 17'h00002; evt_tick = 1'b1;
    m_word = 17'h00003;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; evt_tick = 1'b0;
    check_all("R9");

    // R1 asynchronous reset mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    m_word = '0; m_lvl = '0;
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule